// File: doc/BRIEF.md
# Bus Address Remapping Access Unit

This block is a slave on a fast system bus that owns a small address window divided into numbered, word-sized channels. Each channel holds a target address on a slower peripheral bus. An access to a channel's address in normal operation is passed on to that target. The requester is held until the peripheral side answers.

The same channel address can instead reach the channel's target register. A mode bit decides which one an access hits. Software enters setup mode, writes a target into each channel address, and returns to normal mode. It then switches on the channels it wants. A channel may only forward if it is enabled, the unit is on, and its target lies in the permitted top-of-memory region. Any other access fails with an error response and sets a sticky error flag. That flag can raise an interrupt. Control, status, channel enables and the interrupt mask sit on a separate narrow register port.

Top module: `bus_remap_unit`

## Requirements
- R1: After synchronous reset, status reads 0 (unit off, normal mode, no error), both enable halves read 0, all stored targets are 0 and irq is low.
- R2: The control register is at register offset 0. Writing it with bit 0 set switches the unit on, which status bit 0 (offset 1) then reports. With bit 0 clear and bit 1 set, the write switches the unit off.
- R3: Writing control bit 2 enters setup mode. Writing control bit 3 (with bit 2 clear) returns to normal mode. Status bit 1 reads 1 in setup mode.
- R4: In setup mode, an access to channel k at address BASE + 4k writes or reads target register k. It completes with hs_done in the cycle it is presented and causes no peripheral access.
- R5: Offset 2 sets enables for channels 0 to 7, and offset 3 for channels 8 to 15, one bit per channel, at bit k mod 8. Written zeros have no effect. Offsets 4 and 5 clear the same bits when written with ones. Reads of offsets 2 and 3 return the current enables.
- R6: In normal mode, an access to an enabled channel of a unit that is on, with a target in range, is forwarded. pb_req is raised the cycle after acceptance with the stored target, direction and write data, and held stable until pb_ack. hs_wait stays high until then. hs_done and the read data appear in the pb_ack cycle.
- R7: A target below 0xFFFC0000 is never forwarded. A normal-mode access to such a channel fails.
- R8: A normal-mode access fails if the unit is off, if the channel is disabled, if the address lies outside the window, or if the address is not word aligned. A failing access completes at once with hs_done and hs_err, read data 0, and no forwarding. It sets status bit 2, which stays set until a one is written to that bit at offset 1.
- R9: irq is high exactly while the error flag is set and mask bit 0 at offset 6 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register port access strobe |
| reg_we | input | 1 | Register port write enable |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| hs_valid | input | 1 | Fast-bus request, held until hs_done |
| hs_we | input | 1 | Fast-bus write enable |
| hs_addr | input | 32 | Fast-bus byte address |
| hs_wdata | input | 32 | Fast-bus write data |
| hs_rdata | output | 32 | Fast-bus read data, valid with hs_done |
| hs_done | output | 1 | Access completes this cycle |
| hs_err | output | 1 | Completing access failed |
| hs_wait | output | 1 | Requester must keep holding |
| pb_req | output | 1 | Peripheral request |
| pb_we | output | 1 | Peripheral write enable |
| pb_addr | output | 32 | Peripheral target address |
| pb_wdata | output | 32 | Peripheral write data |
| pb_rdata | input | 32 | Peripheral read data |
| pb_ack | input | 1 | Peripheral acknowledge |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses 16 channels with the window based at 0x4000_0000 and the default target floor of 0xFFFC0000. Sixteen channels fill both enable halves, so enabling channel 15 through the high half and channel 0 through the low half are each tested. An address one word past the last channel falls just outside the window and is tested as well. A peripheral model that answers after two cycles makes the wait period visible. That allows a mid-transfer check of pb_addr and hs_wait. It also allows a count of peripheral accesses, which shows that setup-mode and failing accesses forward nothing.

// File: rtl/remap_pkg.sv
package remap_pkg;
    // register port word offsets
    localparam logic [2:0] OFS_CTRL   = 3'd0;
    localparam logic [2:0] OFS_STAT   = 3'd1;
    localparam logic [2:0] OFS_ENS_LO = 3'd2;
    localparam logic [2:0] OFS_ENS_HI = 3'd3;
    localparam logic [2:0] OFS_ENC_LO = 3'd4;
    localparam logic [2:0] OFS_ENC_HI = 3'd5;
    localparam logic [2:0] OFS_MASK   = 3'd6;

    // control bits (write-one pulses)
    localparam int CB_ON     = 0;
    localparam int CB_OFF    = 1;
    localparam int CB_SETUP  = 2;
    localparam int CB_NORMAL = 3;

    // status bits
    localparam int SB_ON    = 0;
    localparam int SB_SETUP = 1;
    localparam int SB_ERR   = 2;

    typedef enum logic {FWD_IDLE, FWD_BUSY} fwd_state_e;

    typedef struct packed {
        logic [31:0] addr;
        logic        we;
        logic [31:0] wdata;
    } pb_cmd_t;

    function automatic logic target_allowed(input logic [31:0] tgt, input logic [31:0] floor);
        return tgt >= floor;
    endfunction
endpackage

// File: rtl/remap_ctrl_regs.sv
module remap_ctrl_regs
    import remap_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_sel,
    input  logic           reg_we,
    input  logic [2:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic           err_set,
    output logic           unit_on,
    output logic           setup_mode,
    output logic [NCH-1:0] ch_en,
    output logic           err_flag,
    output logic           irq
);
    localparam int HALF = NCH / 2;

    logic           wr;
    logic           mask_q;
    logic [NCH-1:0] set_vec, clr_vec;
    logic           unused_hi;

    assign wr        = reg_sel && reg_we;
    assign unused_hi = ^reg_wdata[31:HALF];

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (wr) begin
            case (reg_addr)
                OFS_ENS_LO: set_vec[HALF-1:0]   = reg_wdata[HALF-1:0];
                OFS_ENS_HI: set_vec[NCH-1:HALF] = reg_wdata[HALF-1:0];
                OFS_ENC_LO: clr_vec[HALF-1:0]   = reg_wdata[HALF-1:0];
                OFS_ENC_HI: clr_vec[NCH-1:HALF] = reg_wdata[HALF-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unit_on    <= 1'b0;
            setup_mode <= 1'b0;
            ch_en      <= '0;
            err_flag   <= 1'b0;
            mask_q     <= 1'b0;
        end else begin
            if (wr && reg_addr == OFS_CTRL) begin
                if (reg_wdata[CB_ON])          unit_on    <= 1'b1;
                else if (reg_wdata[CB_OFF])    unit_on    <= 1'b0;
                if (reg_wdata[CB_SETUP])       setup_mode <= 1'b1;
                else if (reg_wdata[CB_NORMAL]) setup_mode <= 1'b0;
            end
            ch_en <= (ch_en | set_vec) & ~clr_vec;
            if (err_set)
                err_flag <= 1'b1;
            else if (wr && reg_addr == OFS_STAT && reg_wdata[SB_ERR])
                err_flag <= 1'b0;
            if (wr && reg_addr == OFS_MASK)
                mask_q <= reg_wdata[0];
        end
    end

    assign irq = err_flag && mask_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STAT: begin
                reg_rdata[SB_ON]    = unit_on;
                reg_rdata[SB_SETUP] = setup_mode;
                reg_rdata[SB_ERR]   = err_flag;
            end
            OFS_ENS_LO: reg_rdata[HALF-1:0] = ch_en[HALF-1:0];
            OFS_ENS_HI: reg_rdata[HALF-1:0] = ch_en[NCH-1:HALF];
            OFS_MASK:   reg_rdata[0]        = mask_q;
            default: ;
        endcase
    end

    AST_UNIT_ON: assert property (@(posedge clk) disable iff (rst)
        (wr && reg_addr == OFS_CTRL && reg_wdata[CB_ON]) |=> unit_on); // R2
    AST_SETUP_ENTER: assert property (@(posedge clk) disable iff (rst)
        (wr && reg_addr == OFS_CTRL && reg_wdata[CB_SETUP]) |=> setup_mode); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !(wr && reg_addr == OFS_STAT && reg_wdata[SB_ERR])) |=> err_flag); // R8
endmodule

// File: rtl/remap_target_bank.sv
module remap_target_bank #(
    parameter int NCH  = 16,
    parameter int IDXW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [31:0]     wr_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic [31:0]     rd_data
);
    logic [31:0] tgt [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst)
                tgt[g] <= '0;
            else if (wr_en && wr_idx == IDXW'(g))
                tgt[g] <= wr_data;
        end
    end

    assign rd_data = tgt[rd_idx];
endmodule

// File: rtl/remap_fwd_engine.sv
module remap_fwd_engine
    import remap_pkg::*;
#(
    parameter int          NCH   = 16,
    parameter int          IDXW  = $clog2(NCH),
    parameter logic [31:0] BASE  = 32'h4000_0000,
    parameter logic [31:0] FLOOR = 32'hFFFC_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hs_valid,
    input  logic            hs_we,
    input  logic [31:0]     hs_addr,
    input  logic [31:0]     hs_wdata,
    output logic [31:0]     hs_rdata,
    output logic            hs_done,
    output logic            hs_err,
    output logic            hs_wait,
    input  logic            unit_on,
    input  logic            setup_mode,
    input  logic [NCH-1:0]  ch_en,
    output logic [IDXW-1:0] idx,
    output logic            tgt_we,
    input  logic [31:0]     tgt_rdata,
    output logic            pb_req,
    output logic            pb_we,
    output logic [31:0]     pb_addr,
    output logic [31:0]     pb_wdata,
    input  logic [31:0]     pb_rdata,
    input  logic            pb_ack
);
    localparam int WIN_LSB = 2 + IDXW;

    fwd_state_e state;
    pb_cmd_t    cmd;
    logic       in_win, fwd_ok, accept;

    assign idx    = hs_addr[WIN_LSB-1:2];
    assign in_win = (hs_addr[31:WIN_LSB] == BASE[31:WIN_LSB]) && (hs_addr[1:0] == 2'b00);
    assign fwd_ok = in_win && unit_on && ch_en[idx] && target_allowed(tgt_rdata, FLOOR);
    assign accept = (state == FWD_IDLE) && hs_valid && !setup_mode && fwd_ok;

    always_comb begin
        hs_done  = 1'b0;
        hs_err   = 1'b0;
        hs_rdata = '0;
        tgt_we   = 1'b0;
        if (state == FWD_BUSY) begin
            if (pb_ack) begin
                hs_done  = 1'b1;
                hs_rdata = pb_rdata;
            end
        end else if (hs_valid) begin
            if (setup_mode && in_win) begin
                hs_done  = 1'b1;
                tgt_we   = hs_we;
                hs_rdata = hs_we ? '0 : tgt_rdata;
            end else if (setup_mode || !fwd_ok) begin
                hs_done = 1'b1;
                hs_err  = 1'b1;
            end
        end
    end

    assign hs_wait = (hs_valid || state == FWD_BUSY) && !hs_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FWD_IDLE;
            cmd   <= '0;
        end else begin
            case (state)
                FWD_IDLE: if (accept) begin
                    state <= FWD_BUSY;
                    cmd   <= '{addr: tgt_rdata, we: hs_we, wdata: hs_wdata};
                end
                FWD_BUSY: if (pb_ack) state <= FWD_IDLE;
                default:  state <= FWD_IDLE;
            endcase
        end
    end

    assign pb_req   = (state == FWD_BUSY);
    assign pb_we    = cmd.we;
    assign pb_addr  = cmd.addr;
    assign pb_wdata = cmd.wdata;

    AST_PB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pb_req && !pb_ack) |=> (pb_req && $stable(pb_addr) && $stable(pb_we))); // R6
    AST_PB_RANGE: assert property (@(posedge clk) disable iff (rst)
        pb_req |-> (pb_addr >= FLOOR)); // R7
endmodule

// File: rtl/bus_remap_unit.sv
module bus_remap_unit
    import remap_pkg::*;
#(
    parameter int          NCH   = 16,
    parameter logic [31:0] BASE  = 32'h4000_0000,
    parameter logic [31:0] FLOOR = 32'hFFFC_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_sel,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        hs_valid,
    input  logic        hs_we,
    input  logic [31:0] hs_addr,
    input  logic [31:0] hs_wdata,
    output logic [31:0] hs_rdata,
    output logic        hs_done,
    output logic        hs_err,
    output logic        hs_wait,
    output logic        pb_req,
    output logic        pb_we,
    output logic [31:0] pb_addr,
    output logic [31:0] pb_wdata,
    input  logic [31:0] pb_rdata,
    input  logic        pb_ack,
    output logic        irq
);
    localparam int IDXW = $clog2(NCH);

    logic            unit_on, setup_mode, err_flag, tgt_we;
    logic [NCH-1:0]  ch_en;
    logic [IDXW-1:0] idx;
    logic [31:0]     tgt_rdata;

    remap_ctrl_regs #(.NCH(NCH)) u_regs (
        .clk(clk), .rst(rst),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .err_set(hs_err),
        .unit_on(unit_on), .setup_mode(setup_mode), .ch_en(ch_en),
        .err_flag(err_flag), .irq(irq)
    );

    remap_target_bank #(.NCH(NCH), .IDXW(IDXW)) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(tgt_we), .wr_idx(idx), .wr_data(hs_wdata),
        .rd_idx(idx), .rd_data(tgt_rdata)
    );

    remap_fwd_engine #(.NCH(NCH), .IDXW(IDXW), .BASE(BASE), .FLOOR(FLOOR)) u_fwd (
        .clk(clk), .rst(rst),
        .hs_valid(hs_valid), .hs_we(hs_we), .hs_addr(hs_addr), .hs_wdata(hs_wdata),
        .hs_rdata(hs_rdata), .hs_done(hs_done), .hs_err(hs_err), .hs_wait(hs_wait),
        .unit_on(unit_on), .setup_mode(setup_mode), .ch_en(ch_en),
        .idx(idx), .tgt_we(tgt_we), .tgt_rdata(tgt_rdata),
        .pb_req(pb_req), .pb_we(pb_we), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
        .pb_rdata(pb_rdata), .pb_ack(pb_ack)
    );

    AST_FWD_NORMAL_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(pb_req) |-> ($past(unit_on) && !$past(setup_mode))); // R4
    AST_ERR_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        hs_err |=> err_flag); // R8
endmodule

// File: tb/sim_bus_remap_unit.sv
module sim_bus_remap_unit;
    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam logic [2:0] OP_RW = 3'd0, OP_RR = 3'd1, OP_HW = 3'd2,
                           OP_HR = 3'd3, OP_IRQ = 3'd4, OP_PBC = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 53;
    localparam vec_t VEC [NV] = '{
        '{OP_RR,  32'd1, 32'd0, 32'h0, 1'b0, 4'd1},          // R1 status
        '{OP_RR,  32'd2, 32'd0, 32'h0, 1'b0, 4'd1},          // R1 enables
        '{OP_IRQ, 32'd0, 32'd0, 32'h0, 1'b0, 4'd1},          // R1 irq
        '{OP_HR,  BASE,  32'd0, 32'h0, 1'b1, 4'd8},          // R8 unit off
        '{OP_RR,  32'd1, 32'd0, 32'h4, 1'b0, 4'd8},
        '{OP_RW,  32'd1, 32'h4, 32'h0, 1'b0, 4'd8},
        '{OP_RR,  32'd1, 32'd0, 32'h0, 1'b0, 4'd8},          // R8 cleared
        '{OP_RW,  32'd0, 32'h1, 32'h0, 1'b0, 4'd2},
        '{OP_RR,  32'd1, 32'd0, 32'h1, 1'b0, 4'd2},          // R2
        '{OP_RW,  32'd0, 32'h4, 32'h0, 1'b0, 4'd3},
        '{OP_RR,  32'd1, 32'd0, 32'h3, 1'b0, 4'd3},          // R3
        '{OP_HW,  BASE,        32'hFFFC_0010, 32'h0, 1'b0, 4'd4}, // R4
        '{OP_HW,  BASE+32'h3C, 32'hFFFC_0040, 32'h0, 1'b0, 4'd4},
        '{OP_HW,  BASE+32'h0C, 32'h0000_1000, 32'h0, 1'b0, 4'd4},
        '{OP_HW,  BASE+32'h04, 32'hFFFC_0020, 32'h0, 1'b0, 4'd4},
        '{OP_HR,  BASE+32'h3C, 32'd0, 32'hFFFC_0040, 1'b0, 4'd4},
        '{OP_HR,  BASE,        32'd0, 32'hFFFC_0010, 1'b0, 4'd4},
        '{OP_PBC, 32'd0, 32'd0, 32'd0, 1'b0, 4'd4},          // R4 no forwarding
        '{OP_RW,  32'd0, 32'h8, 32'h0, 1'b0, 4'd3},
        '{OP_RR,  32'd1, 32'd0, 32'h1, 1'b0, 4'd3},          // R3 back to normal
        '{OP_HR,  BASE,  32'd0, 32'h0, 1'b1, 4'd8},          // R8 channel off
        '{OP_RW,  32'd1, 32'h4, 32'h0, 1'b0, 4'd8},
        '{OP_RW,  32'd2, 32'h09, 32'h0, 1'b0, 4'd5},
        '{OP_RW,  32'd3, 32'h80, 32'h0, 1'b0, 4'd5},
        '{OP_RR,  32'd2, 32'd0, 32'h09, 1'b0, 4'd5},         // R5
        '{OP_RR,  32'd3, 32'd0, 32'h80, 1'b0, 4'd5},
        '{OP_RW,  32'd2, 32'h00, 32'h0, 1'b0, 4'd5},
        '{OP_RR,  32'd2, 32'd0, 32'h09, 1'b0, 4'd5},         // R5 zeros ignored
        '{OP_HW,  BASE,        32'hA5A5_0001, 32'h0, 1'b0, 4'd6}, // R6
        '{OP_HR,  BASE,        32'd0, 32'hA5A5_0001, 1'b0, 4'd6},
        '{OP_HW,  BASE+32'h3C, 32'h0000_1234, 32'h0, 1'b0, 4'd6},
        '{OP_HR,  BASE+32'h3C, 32'd0, 32'h0000_1234, 1'b0, 4'd6},
        '{OP_PBC, 32'd0, 32'd0, 32'd4, 1'b0, 4'd6},
        '{OP_HR,  BASE+32'h0C, 32'd0, 32'h0, 1'b1, 4'd7},    // R7
        '{OP_RR,  32'd1, 32'd0, 32'h5, 1'b0, 4'd7},
        '{OP_PBC, 32'd0, 32'd0, 32'd4, 1'b0, 4'd7},
        '{OP_RW,  32'd1, 32'h4, 32'h0, 1'b0, 4'd8},
        '{OP_RW,  32'd4, 32'h01, 32'h0, 1'b0, 4'd5},
        '{OP_RR,  32'd2, 32'd0, 32'h08, 1'b0, 4'd5},         // R5 clear
        '{OP_HR,  BASE,  32'd0, 32'h0, 1'b1, 4'd5},
        '{OP_RW,  32'd6, 32'h1, 32'h0, 1'b0, 4'd9},
        '{OP_IRQ, 32'd0, 32'd0, 32'h1, 1'b0, 4'd9},          // R9
        '{OP_RW,  32'd1, 32'h4, 32'h0, 1'b0, 4'd9},
        '{OP_IRQ, 32'd0, 32'd0, 32'h0, 1'b0, 4'd9},
        '{OP_HR,  BASE+32'h40, 32'd0, 32'h0, 1'b1, 4'd8},    // R8 out of window
        '{OP_IRQ, 32'd0, 32'd0, 32'h1, 1'b0, 4'd9},
        '{OP_RW,  32'd6, 32'h0, 32'h0, 1'b0, 4'd9},
        '{OP_IRQ, 32'd0, 32'd0, 32'h0, 1'b0, 4'd9},          // R9 masked
        '{OP_RW,  32'd1, 32'h4, 32'h0, 1'b0, 4'd8},
        '{OP_HR,  BASE+32'h3E, 32'd0, 32'h0, 1'b1, 4'd8},    // R8 misaligned
        '{OP_RW,  32'd0, 32'h2, 32'h0, 1'b0, 4'd2},
        '{OP_RR,  32'd1, 32'd0, 32'h4, 1'b0, 4'd2},          // R2 off (error still set)
        '{OP_HR,  BASE+32'h3C, 32'd0, 32'h0, 1'b1, 4'd8}     // R8 unit off
    };

    logic clk = 1'b0, rst = 1'b1;
    logic reg_sel = 0, reg_we = 0, hs_valid = 0, hs_we = 0, pb_ack = 0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, hs_addr = '0, hs_wdata = '0, pb_rdata = '0;
    logic [31:0] reg_rdata, hs_rdata, pb_addr, pb_wdata;
    logic hs_done, hs_err, hs_wait, pb_req, pb_we, irq;

    int checks = 0, fails = 0, cycles = 0, pb_count = 0, dly = 0;
    logic [31:0] pmem [64];

    always #4 clk = ~clk;

    bus_remap_unit u0 (.*);

    // peripheral model: acknowledges on the second falling edge of a request
    initial for (int i = 0; i < 64; i++) pmem[i] = '0;
    always @(negedge clk) begin
        if (pb_req && !pb_ack) begin
            dly = dly + 1;
            if (dly == 2) begin
                pb_ack   <= 1'b1;
                pb_rdata <= pb_we ? 32'h0 : pmem[pb_addr[7:2]];
                if (pb_we) pmem[pb_addr[7:2]] = pb_wdata;
                pb_count = pb_count + 1;
                dly = 0;
            end
        end else begin
            pb_ack <= 1'b0;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog expired act=%0d exp<=20000 cycles", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 0; reg_we = 0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1; reg_we = 0; reg_addr = a;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_sel = 0;
    endtask

    task automatic hs_xfer(input logic we, input logic [31:0] a, input logic [31:0] d,
                           output logic [31:0] rd, output logic er);
        @(negedge clk);
        hs_valid = 1; hs_we = we; hs_addr = a; hs_wdata = d;
        #2;
        while (!hs_done) begin
            @(negedge clk);
            #2;
        end
        rd = hs_rdata; er = hs_err;
        @(negedge clk);
        hs_valid = 0; hs_we = 0;
    endtask

    initial begin
        logic [31:0] rd;
        logic        er;
        repeat (3) @(negedge clk);
        rst = 0;
        chk(1, {31'd0, irq}, 32'd0);                         // R1 irq low after reset
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_RW: reg_wr(VEC[i].addr[2:0], VEC[i].data);
                OP_RR: begin
                    reg_rd(VEC[i].addr[2:0], rd);
                    chk(int'(VEC[i].req), rd, VEC[i].exp);
                end
                OP_HW: begin
                    hs_xfer(1'b1, VEC[i].addr, VEC[i].data, rd, er);
                    chk(int'(VEC[i].req), {31'd0, er}, {31'd0, VEC[i].err});
                end
                OP_HR: begin
                    hs_xfer(1'b0, VEC[i].addr, 32'd0, rd, er);
                    chk(int'(VEC[i].req), rd, VEC[i].exp);
                    chk(int'(VEC[i].req), {31'd0, er}, {31'd0, VEC[i].err});
                end
                OP_IRQ: begin
                    @(negedge clk); #2;
                    chk(int'(VEC[i].req), {31'd0, irq}, VEC[i].exp);
                end
                default: chk(int'(VEC[i].req), pb_count, VEC[i].exp);
            endcase
        end

        // directed R6: the wait phase of a forwarded read of channel 15
        reg_wr(3'd1, 32'h4);
        reg_wr(3'd0, 32'h1);
        @(negedge clk);
        hs_valid = 1; hs_we = 0; hs_addr = BASE + 32'h3C;
        #2 chk(6, {30'd0, hs_wait, hs_done}, 32'b10);        // R6 held in accept cycle
        @(negedge clk); #2;
        chk(6, {31'd0, pb_req}, 32'd1);                      // R6 request raised
        chk(6, pb_addr, 32'hFFFC_0040);                      // R6 stored target
        chk(6, {31'd0, hs_wait}, 32'd1);
        @(negedge clk); #2;
        chk(6, {31'd0, hs_done}, 32'd1);                     // R6 done with ack
        chk(6, hs_rdata, 32'h0000_1234);
        @(negedge clk);
        hs_valid = 0;

        // directed R1: reset again clears enables and the unit state
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        reg_rd(3'd3, rd); chk(1, rd, 32'h0);                 // R1 high enables cleared
        reg_rd(3'd1, rd); chk(1, rd, 32'h0);                 // R1 status cleared
        reg_wr(3'd0, 32'h4);
        hs_xfer(1'b0, BASE + 32'h3C, 32'd0, rd, er);
        chk(1, rd, 32'h0);                                   // R1 targets cleared

        summary();
        $finish;
    end
endmodule